// File: doc/BRIEF.md
# Address Match and Slot Allocator

This block chooses the table slot that an add operation should overwrite in a forwarding table of address and VLAN entries. A requester pulses a start input together with a search key: a 48-bit MAC address, a 12-bit VLAN ID, a flag saying whether the VLAN ID applies, and a search mode. The block then reads the table through a read port that returns one entry per cycle, one cycle after the index is presented. It scans the entries in ascending index order from index 0.

In address mode a single pass looks for three things. The first is an existing entry with the same key. The second is the lowest-index empty entry. The third is the lowest-index entry that may be evicted. An existing match ends the pass at once. Otherwise the pass runs to the last index and reports the best candidate. In VLAN mode the block looks only for a VLAN-type entry carrying the requested VLAN ID. The block never writes the table; the requester performs the write using the returned index.

The controller is a four-state machine:
- IDLE waits for start and moves to SCAN on a start pulse (transition "accept").
- SCAN issues one read per cycle. It moves to DONE when an exact hit is found ("early hit"), or to TAIL once the last index has been issued ("last issued").
- TAIL evaluates the final returned entry and moves to DONE ("resolve").
- DONE raises the done pulse for one cycle and returns to IDLE ("retire").

Top module: `mac_slot_finder`

## Requirements
- R1: In address mode, an entry matches only if its kind field (bits 61:60) is 1 (address) or 3 (VLAN+address), its VLAN field (bits 59:48) equals the search VLAN ID, and its bits 47:0 equal the requested MAC.
- R2: In address mode with the VLAN flag low, the search VLAN ID is 0 regardless of the VLAN ID input. With the flag high, the VLAN ID input is used.
- R3: The result priority is match (reason 0), then empty (reason 1), then evictable (reason 2), then none (reason 3). The found output is high exactly when the reason is not 3.
- R4: When reporting an empty or evictable slot, the index is the lowest index of that category. When reporting a match, the index is the lowest matching index.
- R5: An entry is evictable only if its kind is 1 or 3, its bit 40 (group bit) is 0, and its class field (bits 63:62) is 1 or 3. Class 0 and class 2 entries are never evicted. An entry is empty when its kind is 0.
- R6: In VLAN mode (mode input 1), only kind-2 entries whose VLAN field equals the VLAN ID input match. Otherwise the reason is 3, even if empty or evictable entries exist.
- R7: The read port presents indices 0, 1, 2, … in consecutive cycles, starting with the cycle after start is accepted. It does not read while idle.
- R8: A match at index k gives the done pulse k+2 clock edges after the start edge. Any other result gives it NUM_ENTRIES+1 edges after the start edge. Done lasts one cycle.
- R9: A start pulse that arrives while the block is busy is ignored: the running search's result and timing do not change.
- R10: After reset, done, busy and read enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| mode_i | input | 1 | 0 = address search, 1 = VLAN search |
| vlan_flag_i | input | 1 | Address mode: the VLAN ID input applies |
| vid_i | input | 12 | Requested VLAN ID |
| mac_i | input | 48 | Requested MAC, first byte in bits 47:40 |
| rd_en_o | output | 1 | Table read request |
| rd_idx_o | output | IDX_W | Table index being read |
| rd_data_i | input | 64 | Table entry, valid the cycle after the request |
| busy_o | output | 1 | A search is in progress |
| done_o | output | 1 | One-cycle result pulse |
| found_o | output | 1 | A slot was found |
| reason_o | output | 2 | 0 match, 1 empty, 2 evictable, 3 none |
| idx_o | output | IDX_W | Selected slot index |

## Verification
The result is due k+2 edges after the start edge for a match at index k, and NUM_ENTRIES+1 edges after it otherwise. The bench counts edges from the start edge until done is seen and compares that count with the value its reference model predicts. Inputs are driven and outputs sampled on the falling edge, so every count refers to whole rising edges. The reason, index and found outputs are compared in the same sample in which done is first seen high.

// File: rtl/slot_find_pkg.sv
package slot_find_pkg;
    localparam int ENTRY_W   = 64;
    localparam int MAC_W     = 48;
    localparam int VID_W     = 12;
    localparam int GROUP_BIT = 40;

    typedef enum logic [1:0] {
        KIND_EMPTY     = 2'd0,
        KIND_ADDR      = 2'd1,
        KIND_VLAN      = 2'd2,
        KIND_VLAN_ADDR = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        RSN_MATCH = 2'd0,
        RSN_FREE  = 2'd1,
        RSN_EVICT = 2'd2,
        RSN_NONE  = 2'd3
    } reason_e;

    typedef enum logic {
        SRCH_ADDR = 1'b0,
        SRCH_VLAN = 1'b1
    } search_e;

    typedef struct packed {
        logic [1:0]       uc_class;
        kind_e            kind;
        logic [VID_W-1:0] vid;
        logic [MAC_W-1:0] mac;
    } entry_t;
endpackage

// File: rtl/slot_classify.sv
module slot_classify
    import slot_find_pkg::*;
(
    input  entry_t           ent_i,
    input  search_e          mode_i,
    input  logic [VID_W-1:0] vid_i,
    input  logic [MAC_W-1:0] mac_i,
    output logic             match_o,
    output logic             free_o,
    output logic             evict_o
);
    logic is_addr;
    logic vid_eq;
    logic mac_eq;
    logic class_ok;

    always_comb begin
        is_addr  = (ent_i.kind == KIND_ADDR) || (ent_i.kind == KIND_VLAN_ADDR);
        vid_eq   = (ent_i.vid == vid_i);
        mac_eq   = (ent_i.mac == mac_i);
        class_ok = (ent_i.uc_class == 2'd1) || (ent_i.uc_class == 2'd3);
        if (mode_i == SRCH_VLAN) begin
            match_o = (ent_i.kind == KIND_VLAN) && vid_eq;
            free_o  = 1'b0;
            evict_o = 1'b0;
        end else begin
            match_o = is_addr && vid_eq && mac_eq;
            free_o  = (ent_i.kind == KIND_EMPTY);
            evict_o = is_addr && !ent_i.mac[GROUP_BIT] && class_ok;
        end
    end
endmodule

// File: rtl/slot_first_latch.sv
module slot_first_latch #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             hit_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             have_o,
    output logic [IDX_W-1:0] idx_o
);
    logic             have_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            idx_q  <= '0;
        end else if (clr_i) begin
            have_q <= 1'b0;
            idx_q  <= '0;
        end else if (en_i && hit_i && !have_q) begin
            have_q <= 1'b1;
            idx_q  <= idx_i;
        end
    end

    // look-through so the entry under evaluation counts in the same cycle
    always_comb begin
        have_o = have_q || (en_i && hit_i);
        idx_o  = have_q ? idx_q : idx_i;
    end
endmodule

// File: rtl/slot_scan_ctrl.sv
module slot_scan_ctrl
    import slot_find_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    parameter int IDX_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             hit_match_i,
    input  logic             free_have_i,
    input  logic [IDX_W-1:0] free_idx_i,
    input  logic             evict_have_i,
    input  logic [IDX_W-1:0] evict_idx_i,
    output logic             accept_o,
    output logic             rd_en_o,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic             chk_en_o,
    output logic [IDX_W-1:0] chk_idx_o,
    output logic             busy_o,
    output logic             done_o,
    output reason_e          reason_o,
    output logic [IDX_W-1:0] idx_o
);
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_TAIL = 2'd2,
        ST_DONE = 2'd3
    } state_e;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    state_e           state_q, state_d;
    logic [IDX_W-1:0] ptr_q;
    logic             chk_valid_q;
    logic [IDX_W-1:0] chk_idx_q;
    reason_e          res_reason_q, fin_reason;
    logic [IDX_W-1:0] res_idx_q, fin_idx;
    logic             finish;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // final priority: match, then empty, then evictable
    always_comb begin
        if (chk_en_o && hit_match_i) begin
            fin_reason = RSN_MATCH;
            fin_idx    = chk_idx_q;
        end else if (free_have_i) begin
            fin_reason = RSN_FREE;
            fin_idx    = free_idx_i;
        end else if (evict_have_i) begin
            fin_reason = RSN_EVICT;
            fin_idx    = evict_idx_i;
        end else begin
            fin_reason = RSN_NONE;
            fin_idx    = '0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_SCAN;
            ST_SCAN: begin
                if (chk_en_o && hit_match_i) begin
                    state_d = ST_DONE;
                    finish  = 1'b1;
                end else if (ptr_q == LAST_IDX) begin
                    state_d = ST_TAIL;
                end
            end
            ST_TAIL: begin
                state_d = ST_DONE;
                finish  = 1'b1;
            end
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept_o  = start_i && (state_q == ST_IDLE);
        rd_en_o   = (state_q == ST_SCAN);
        rd_idx_o  = ptr_q;
        chk_en_o  = chk_valid_q && ((state_q == ST_SCAN) || (state_q == ST_TAIL));
        chk_idx_o = chk_idx_q;
        busy_o    = (state_q != ST_IDLE);
        done_o    = (state_q == ST_DONE);
        reason_o  = res_reason_q;
        idx_o     = res_idx_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q        <= '0;
            chk_valid_q  <= 1'b0;
            chk_idx_q    <= '0;
            res_reason_q <= RSN_NONE;
            res_idx_q    <= '0;
        end else begin
            chk_valid_q <= rd_en_o;
            chk_idx_q   <= ptr_q;
            if (accept_o)                ptr_q <= '0;
            else if (state_q == ST_SCAN) ptr_q <= ptr_q + 1'b1;
            if (finish) begin
                res_reason_q <= fin_reason;
                res_idx_q    <= fin_idx;
            end
        end
    end
endmodule

// File: rtl/mac_slot_finder.sv
module mac_slot_finder
    import slot_find_pkg::*;
#(
    parameter int  NUM_ENTRIES = 64,
    localparam int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               mode_i,
    input  logic               vlan_flag_i,
    input  logic [VID_W-1:0]   vid_i,
    input  logic [MAC_W-1:0]   mac_i,
    output logic               rd_en_o,
    output logic [IDX_W-1:0]   rd_idx_o,
    input  logic [ENTRY_W-1:0] rd_data_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               found_o,
    output logic [1:0]         reason_o,
    output logic [IDX_W-1:0]   idx_o
);
    localparam int N_CAND = 2;

    search_e          mode_q;
    logic [VID_W-1:0] vid_q;
    logic [MAC_W-1:0] mac_q;
    logic             accept;
    logic             chk_en;
    logic [IDX_W-1:0] chk_idx;
    logic             hit_match, hit_free, hit_evict;
    logic             cand_hit  [N_CAND];
    logic             cand_have [N_CAND];
    logic [IDX_W-1:0] cand_idx  [N_CAND];
    reason_e          reason;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= SRCH_ADDR;
            vid_q  <= '0;
            mac_q  <= '0;
        end else if (accept) begin
            mode_q <= search_e'(mode_i);
            vid_q  <= (mode_i || vlan_flag_i) ? vid_i : '0;
            mac_q  <= mac_i;
        end
    end

    slot_classify u_classify (
        .ent_i   (entry_t'(rd_data_i)),
        .mode_i  (mode_q),
        .vid_i   (vid_q),
        .mac_i   (mac_q),
        .match_o (hit_match),
        .free_o  (hit_free),
        .evict_o (hit_evict)
    );

    assign cand_hit[0] = hit_free;
    assign cand_hit[1] = hit_evict;

    for (genvar g = 0; g < N_CAND; g++) begin : g_cand
        slot_first_latch #(.IDX_W(IDX_W)) u_first (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (accept),
            .en_i   (chk_en),
            .hit_i  (cand_hit[g]),
            .idx_i  (chk_idx),
            .have_o (cand_have[g]),
            .idx_o  (cand_idx[g])
        );
    end

    slot_scan_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .hit_match_i  (hit_match),
        .free_have_i  (cand_have[0]),
        .free_idx_i   (cand_idx[0]),
        .evict_have_i (cand_have[1]),
        .evict_idx_i  (cand_idx[1]),
        .accept_o     (accept),
        .rd_en_o      (rd_en_o),
        .rd_idx_o     (rd_idx_o),
        .chk_en_o     (chk_en),
        .chk_idx_o    (chk_idx),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .reason_o     (reason),
        .idx_o        (idx_o)
    );

    assign reason_o = reason;
    assign found_o  = (reason != RSN_NONE);
endmodule

// File: rtl/mac_slot_finder_chk.sv
module mac_slot_finder_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             rd_en_o,
    input logic [IDX_W-1:0] rd_idx_o,
    input logic             done_o,
    input logic             found_o,
    input logic [1:0]       reason_o,
    input logic             mode_q
);
    p_rd_ascend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o)) |-> (rd_idx_o == IDX_W'($past(rd_idx_o) + 1'b1)));

    p_rd_from_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en_o) |-> (rd_idx_o == '0));

    p_no_idle_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_en_o);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_found_reason_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (found_o == (reason_o != 2'd3)));

    p_vlan_reason_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_q) |-> ((reason_o == 2'd0) || (reason_o == 2'd3)));

    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
endmodule

bind mac_slot_finder mac_slot_finder_chk #(.IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .rd_en_o  (rd_en_o),
    .rd_idx_o (rd_idx_o),
    .done_o   (done_o),
    .found_o  (found_o),
    .reason_o (reason_o),
    .mode_q   (mode_q)
);

// File: tb/tb_mac_slot_finder.sv
`timescale 1ns/1ps
module tb_mac_slot_finder;
    localparam int NE = 64;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic          vlan_flag_i = 1'b0;
    logic [11:0]   vid_i = '0;
    logic [47:0]   mac_i = '0;
    logic          rd_en_o;
    logic [IW-1:0] rd_idx_o;
    logic [63:0]   rd_data_i;
    logic          busy_o, done_o, found_o;
    logic [1:0]    reason_o;
    logic [IW-1:0] idx_o;

    logic [63:0] tbl [NE];
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    mac_slot_finder #(.NUM_ENTRIES(NE)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .vlan_flag_i(vlan_flag_i), .vid_i(vid_i), .mac_i(mac_i),
        .rd_en_o(rd_en_o), .rd_idx_o(rd_idx_o), .rd_data_i(rd_data_i),
        .busy_o(busy_o), .done_o(done_o), .found_o(found_o),
        .reason_o(reason_o), .idx_o(idx_o)
    );

    always_ff @(posedge clk) if (rd_en_o) rd_data_i <= tbl[rd_idx_o];

    function automatic logic [63:0] mk(input logic [1:0] cls, input logic [1:0] kind,
                                       input logic [11:0] vid, input logic [47:0] mac);
        return {cls, kind, vid, mac};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model built from the requirements
    task automatic model(input bit mode, input bit flag, input logic [11:0] vid,
                         input logic [47:0] mac, output int rsn, output int idx, output int lat);
        logic [11:0] ev;
        int fr, evi;
        ev = (mode || flag) ? vid : 12'd0;
        fr = -1; evi = -1;
        for (int k = 0; k < NE; k++) begin
            logic [1:0] cls, kind;
            logic [11:0] v;
            logic [47:0] m;
            {cls, kind, v, m} = tbl[k];
            if (mode) begin
                if (kind == 2'd2 && v == ev) begin rsn = 0; idx = k; lat = k + 2; return; end
            end else begin
                if ((kind == 2'd1 || kind == 2'd3) && v == ev && m == mac) begin
                    rsn = 0; idx = k; lat = k + 2; return;
                end
                if (kind == 2'd0 && fr < 0) fr = k;
                if ((kind == 2'd1 || kind == 2'd3) && !m[40] && (cls == 2'd1 || cls == 2'd3) && evi < 0)
                    evi = k;
            end
        end
        lat = NE + 1;
        if (fr >= 0)       begin rsn = 1; idx = fr; end
        else if (evi >= 0) begin rsn = 2; idx = evi; end
        else               begin rsn = 3; idx = 0; end
    endtask

    task automatic run(input bit mode, input bit flag, input logic [11:0] vid,
                       input logic [47:0] mac, input bit inj, input string req);
        int ersn, eidx, elat, cnt;
        model(mode, flag, vid, mac, ersn, eidx, elat);
        @(negedge clk);
        mode_i = mode; vlan_flag_i = flag; vid_i = vid; mac_i = mac; start_i = 1'b1;
        cnt = 0;
        while (1) begin
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            if (inj && cnt == 2) begin
                // R9: second start with a different key while busy
                start_i = 1'b1; mode_i = ~mode; vlan_flag_i = ~flag;
                vid_i = vid + 12'd1; mac_i = ~mac;
            end
            if (done_o) break;
            cnt++;
            if (cnt > NE + 10) break;
        end
        start_i = 1'b0;
        chk(done_o == 1'b1, {req, " R8 done seen"}, done_o, 1);
        chk(cnt == elat, {req, " R8 latency"}, cnt, elat);
        chk(int'(reason_o) == ersn, {req, " R3 reason"}, reason_o, ersn);
        if (ersn != 3) chk(int'(idx_o) == eidx, {req, " R4 index"}, idx_o, eidx);
        chk(found_o == (ersn != 3), {req, " R3 found"}, found_o, ersn != 3);
        @(negedge clk);
        chk(done_o == 1'b0, {req, " R8 one-cycle done"}, done_o, 0);
    endtask

    task automatic fill(input logic [63:0] v);
        for (int k = 0; k < NE; k++) tbl[k] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [47:0] ma;
        process::self().srandom(32'd1234);
        ma = 48'h0011_2233_4455;
        fill(64'd0);
        repeat (3) @(negedge clk);
        chk(done_o == 0 && busy_o == 0 && rd_en_o == 0, "R10 reset", {done_o, busy_o, rd_en_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 0, "R10 idle after reset", busy_o, 0);

        // R3/R4: empty table gives empty slot 0
        run(0, 0, 0, ma, 0, "empty");
        // R5: all persistent unicast -> none
        fill(mk(2'd0, 2'd1, 12'd0, 48'h0000_0000_0099));
        run(0, 0, 0, ma, 0, "full none");
        // R5: group bit and class 2 never evicted, class 3 at 40 is
        tbl[10] = mk(2'd1, 2'd1, 12'd0, 48'h0100_0000_0001);
        tbl[20] = mk(2'd2, 2'd3, 12'd0, 48'h0000_0000_0002);
        tbl[40] = mk(2'd3, 2'd3, 12'd5, 48'h0000_0000_0003);
        tbl[50] = mk(2'd1, 2'd1, 12'd0, 48'h0000_0000_0004);
        run(0, 0, 0, ma, 0, "evict R5");
        // R3: empty beats evictable
        tbl[55] = 64'd0;
        run(0, 0, 0, ma, 0, "free beats evict");
        // R1/R3: match at 50 beats empty at 5
        tbl[5] = 64'd0;
        tbl[50] = mk(2'd0, 2'd1, 12'd0, ma);
        run(0, 0, 12'd9, ma, 0, "match R1 R2 no flag");
        // R2: flag high with vid 9 does not hit the vid-0 entry
        run(0, 1, 12'd9, ma, 0, "flag vid R2");
        // R1: kind 3 with vid 9 matches; kind 2 with same fields does not
        tbl[30] = mk(2'd0, 2'd2, 12'd9, ma);
        tbl[45] = mk(2'd0, 2'd3, 12'd9, ma);
        run(0, 1, 12'd9, ma, 0, "kind3 R1");
        // R6: VLAN mode finds kind-2 only
        tbl[2] = mk(2'd0, 2'd1, 12'd100, ma);
        tbl[63] = mk(2'd0, 2'd2, 12'd100, 48'h0);
        run(1, 0, 12'd100, ma, 0, "vlan last R6");
        run(1, 0, 12'd77, ma, 0, "vlan absent R6");
        // R9: start while busy ignored
        run(0, 0, 0, ma, 1, "busy start R9");
        run(1, 0, 12'd9, ma, 1, "busy start vlan R9");

        // random mix
        for (int t = 0; t < 150; t++) begin
            bit md, fl;
            logic [11:0] v;
            logic [47:0] m;
            for (int k = 0; k < NE; k++) begin
                logic [1:0] kd;
                kd = 2'($urandom % 4);
                if (($urandom % 3) != 0 && kd == 2'd0) kd = 2'd1;
                tbl[k] = mk(2'($urandom), kd, 12'($urandom % 4),
                            {7'd0, 1'($urandom), 32'd0, 8'($urandom % 8)});
            end
            md = (($urandom % 4) == 0);
            fl = 1'($urandom);
            v  = 12'($urandom % 4);
            m  = {7'd0, 1'($urandom), 32'd0, 8'($urandom % 8)};
            run(md, fl, v, m, (t % 10) == 3, "random R1 R3 R4 R5 R6");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule